// File: doc/BRIEF.md
# Posted/Pending Priority Interrupt Controller

This block collects interrupt events from a set of sources on behalf of a small CPU. Each event sets a sticky posted bit. A posted bit does not request service by itself. It becomes pending only while software has its mask bit set, so an event that arrives while masked is kept and is raised later, once the mask opens. A fixed-priority encoder picks the lowest-numbered pending source. The block drives a request and a vector index to the CPU, but only while the global enable input is high.

Software writes a mask register and a clear register through a one-word write port, and it can clear every posted bit with a single strobe. It reads the posted state directly from an output port. The CPU takes a request by pulsing an acknowledge. That pulse removes the posted bit of the source that was presented, and the request and vector then move to whatever remains pending.

Top module: `intc_prio_ctrl`

## Requirements
- R1: When `evt_i[k]` is high during a cycle, `posted_o[k]` is 1 after the next rising edge, whatever the mask holds.
- R2: A posted bit stays 1 until an acknowledge, a clear-register write or a clear-all strobe removes it. Posted bits never set without an event.
- R3: A source is pending only when both its posted bit and its mask bit are 1. A write with `wr_addr_i`=0 loads the mask from `wr_data_i`. A source posted while masked raises `irq_o` in the cycle after its mask bit is written to 1.
- R4: Among the pending sources, the lowest-numbered one wins. `irq_vec_o` equals its source number.
- R5: `irq_o` is 1 only if `gie_i` was 1 in the cycle before. A pending source is presented one cycle after `gie_i` rises.
- R6: A write with `wr_addr_i`=1 clears each posted bit whose data bit is 1. Posted bits whose data bit is 0 stay unchanged.
- R7: A one-cycle `clr_all_i` clears every posted bit.
- R8: If an event and a clear of the same bit (register clear, clear-all or acknowledge) arrive in the same cycle, the event wins and the bit stays posted.
- R9: `ack_i` while `irq_o` is 1 clears `posted_o[irq_vec_o]`. In the next cycle `irq_o` is 0 unless another source is pending, in which case `irq_vec_o` moves to the next winner.
- R10: After a synchronous reset, the posted bits, the mask, `irq_o` and `irq_vec_o` are all 0.
- R11: `irq_o` and `irq_vec_o` are registered. They update on the same edge as the posted bits, so an unmasked event with the enable high is presented one cycle after it occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N | Source event, one bit per source, sampled every cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 = mask, 1 = clear |
| wr_data_i | input | N | Write data |
| clr_all_i | input | 1 | Clear-all strobe for the posted bits |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | CPU acknowledge of the presented request |
| posted_o | output | N | Current posted bits |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | clog2(N) | Vector index of the presented source |

## Verification
Events are first raised while masked. This shows that posting and pending are kept apart: the bit is posted but no request follows until the mask opens. Events are then raised on two sources at once and acknowledged one after the other, which shows that the lower number wins and that the vector moves on after each acknowledge. Partial clear patterns with both 1 and 0 data bits show that only the marked bits are removed. Events that coincide with a register clear, a clear-all or an acknowledge of the same bit show that setting wins. Holding the enable low separates request gating from posting.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic {
    REG_MASK  = 1'b0,
    REG_CLEAR = 1'b1
  } intc_reg_e;
endpackage

// File: rtl/intc_post_bank.sv
module intc_post_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] nxt_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    // a new event overrides any clear in the same cycle
    assign nxt_o[k] = set_i[k] | (q_o[k] & ~clr_i[k]);
    always_ff @(posedge clk) begin
      if (rst) q_o[k] <= 1'b0;
      else     q_o[k] <= nxt_o[k];
    end
  end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] nxt_o
);
  assign nxt_o = wr_i ? d_i : q_o;

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= nxt_o;
  end
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    // scan downward so the lowest set index is the last one assigned
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/intc_prio_ctrl.sv
module intc_prio_ctrl #(
  parameter int N = 8,
  localparam int VW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  evt_i,
  input  logic          wr_en_i,
  input  logic          wr_addr_i,
  input  logic [N-1:0]  wr_data_i,
  input  logic          clr_all_i,
  input  logic          gie_i,
  input  logic          ack_i,
  output logic [N-1:0]  posted_o,
  output logic          irq_o,
  output logic [VW-1:0] irq_vec_o
);
  import intc_pkg::*;

  logic [N-1:0]  mask_q, mask_nxt;
  logic [N-1:0]  posted_nxt, clr_vec, ack_hot, pend;
  logic          pend_any;
  logic [VW-1:0] pend_idx;
  logic          irq_q;
  logic [VW-1:0] vec_q;
  logic          wr_mask, wr_clr, ack_take;

  assign wr_mask  = wr_en_i && (intc_reg_e'(wr_addr_i) == REG_MASK);
  assign wr_clr   = wr_en_i && (intc_reg_e'(wr_addr_i) == REG_CLEAR);
  assign ack_take = ack_i && irq_q;
  assign ack_hot  = ack_take ? (N'(1) << vec_q) : '0;
  assign clr_vec  = (wr_clr ? wr_data_i : '0) | {N{clr_all_i}} | ack_hot;

  intc_mask_reg #(.N(N)) u_mask (
    .clk(clk), .rst(rst), .wr_i(wr_mask), .d_i(wr_data_i),
    .q_o(mask_q), .nxt_o(mask_nxt)
  );

  intc_post_bank #(.N(N)) u_post (
    .clk(clk), .rst(rst), .set_i(evt_i), .clr_i(clr_vec),
    .q_o(posted_o), .nxt_o(posted_nxt)
  );

  // pending is taken from next state so the request moves on the same edge
  assign pend = posted_nxt & mask_nxt;

  intc_prio_enc #(.N(N), .IW(VW)) u_enc (
    .req_i(pend), .any_o(pend_any), .idx_o(pend_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= gie_i && pend_any;
      vec_q <= pend_idx;
    end
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;
endmodule

// File: rtl/intc_prio_ctrl_chk.sv
module intc_prio_ctrl_chk #(
  parameter int N  = 8,
  parameter int VW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  evt_i,
  input logic          clr_all_i,
  input logic          gie_i,
  input logic          ack_i,
  input logic [N-1:0]  posted_o,
  input logic          irq_o,
  input logic [VW-1:0] irq_vec_o,
  input logic [N-1:0]  mask_q
);
  // R1
  evt_post_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((posted_o & $past(evt_i)) == $past(evt_i)));

  // R2
  no_spurious_post_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((posted_o & ~$past(posted_o) & ~$past(evt_i)) == '0));

  // R3
  irq_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (posted_o[irq_vec_o] && mask_q[irq_vec_o]));

  // R4
  prio_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((posted_o & mask_q & ((N'(1) << irq_vec_o) - N'(1))) == '0));

  // R5
  gie_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> !irq_o);

  // R7
  clr_all_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_all_i && evt_i == '0) |=> (posted_o == '0));

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o && !evt_i[irq_vec_o]) |=> !posted_o[$past(irq_vec_o)]);
endmodule

bind intc_prio_ctrl intc_prio_ctrl_chk #(.N(N), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .clr_all_i(clr_all_i),
  .gie_i(gie_i), .ack_i(ack_i), .posted_o(posted_o), .irq_o(irq_o),
  .irq_vec_o(irq_vec_o), .mask_q(mask_q)
);

// File: tb/intc_prio_ctrl_bench.sv
module intc_prio_ctrl_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] evt_i = '0;
  logic         wr_en_i = 1'b0;
  logic         wr_addr_i = 1'b0;
  logic [N-1:0] wr_data_i = '0;
  logic         clr_all_i = 1'b0;
  logic         gie_i = 1'b0;
  logic         ack_i = 1'b0;
  logic [N-1:0] posted_o;
  logic         irq_o;
  logic [2:0]   irq_vec_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intc_prio_ctrl #(.N(N)) u_intc_prio_ctrl (
    .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .clr_all_i(clr_all_i),
    .gie_i(gie_i), .ack_i(ack_i), .posted_o(posted_o), .irq_o(irq_o),
    .irq_vec_o(irq_vec_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock with the given stimulus, inputs return to idle afterwards
  task automatic step();
    @(negedge clk);
    evt_i = '0; wr_en_i = 1'b0; clr_all_i = 1'b0; ack_i = 1'b0;
  endtask

  task automatic wr(input logic addr, input logic [N-1:0] d);
    wr_en_i = 1'b1; wr_addr_i = addr; wr_data_i = d;
  endtask

  task automatic t_reset();
    check("R10 posted", int'(posted_o), 0);
    check("R10 irq", int'(irq_o), 0);
    check("R10 vec", int'(irq_vec_o), 0);
  endtask

  task automatic t_masked_latch();
    gie_i = 1'b1;
    evt_i = 8'h08; step();
    check("R1 posted while masked", int'(posted_o), 'h08);
    check("R3 no irq while masked", int'(irq_o), 0);
    repeat (3) step();
    check("R2 posted held", int'(posted_o), 'h08);
    wr(1'b0, 8'h08); step();
    check("R3 irq after unmask", int'(irq_o), 1);
    check("R3 vec after unmask", int'(irq_vec_o), 3);
    wr(1'b1, 8'h08); step();
    check("R6 single clear", int'(posted_o), 0);
    check("R6 irq drops", int'(irq_o), 0);
    wr(1'b0, 8'hFF); step();
  endtask

  task automatic t_priority_ack();
    evt_i = 8'h24; step();
    check("R11 irq one cycle after event", int'(irq_o), 1);
    check("R4 lowest wins", int'(irq_vec_o), 2);
    ack_i = 1'b1; step();
    check("R9 ack clears selected", int'(posted_o), 'h20);
    check("R9 irq stays for next", int'(irq_o), 1);
    check("R9 vec moves", int'(irq_vec_o), 5);
    ack_i = 1'b1; step();
    check("R9 all taken", int'(posted_o), 0);
    check("R9 irq drops", int'(irq_o), 0);
  endtask

  task automatic t_gie();
    gie_i = 1'b0;
    evt_i = 8'h80; step();
    check("R5 posted with gie low", int'(posted_o), 'h80);
    check("R5 no irq with gie low", int'(irq_o), 0);
    gie_i = 1'b1; step();
    check("R5 irq after gie", int'(irq_o), 1);
    check("R4 vec top source", int'(irq_vec_o), 7);
    clr_all_i = 1'b1; step();
    check("R7 clear all", int'(posted_o), 0);
    check("R7 irq drops", int'(irq_o), 0);
  endtask

  task automatic t_partial_clear();
    evt_i = 8'h64; step();
    wr(1'b1, 8'h24); step();
    check("R6 write-1 clears, write-0 keeps", int'(posted_o), 'h40);
    check("R6 vec after clear", int'(irq_vec_o), 6);
    clr_all_i = 1'b1; step();
    check("R7 clear all", int'(posted_o), 0);
  endtask

  task automatic t_set_wins();
    evt_i = 8'h10; step();
    evt_i = 8'h10; wr(1'b1, 8'h10); step();
    check("R8 event beats clear write", int'(posted_o), 'h10);
    evt_i = 8'h01; clr_all_i = 1'b1; step();
    check("R8 event beats clear all", int'(posted_o), 'h01);
    check("R4 vec zero", int'(irq_vec_o), 0);
    evt_i = 8'h01; ack_i = 1'b1; step();
    check("R8 event beats ack", int'(posted_o), 'h01);
    check("R8 irq kept", int'(irq_o), 1);
    clr_all_i = 1'b1; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_masked_latch();
    t_priority_ack();
    t_gie();
    t_partial_clear();
    t_set_wins();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule